// File: doc/BRIEF.md
# Contact-Card Power Sequencer

This block drives the power-up and power-down ordering of a contact smart-card slot. A slow oscillator tick times every step. One time unit T is 64 ticks, and the block counts in half-units of 32 ticks. When the host pulls its active-low session line low, the block brings up these outputs in turn: the charge-pump enable, the card supply, the data-line buffers, the card clock, and finally the pass-through of the host's reset request to the card.

When the host releases the session line, the same step counter runs backwards. Card reset drops first, then the clock, the data lines, the card supply and, last of all, the pump. A supply overcurrent, an overtemperature, a supply drop or the removal of the card during a session starts the same backward run at once. It also drives the active-low status flag low. Outside a session, that flag shows whether a card is seated.

Top module: `card_seq_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, every enable output and `card_rst` is 0, and `status_n` shows card presence.
- R2: In the idle state, a session starts when all of the following hold: `sess_n` is sampled low, `sess_n` has been seen high in idle since the last session, a card is present, `supply_ok` is 1, `supply_inhibit` is 0 and no fault is latched. `pump_en` is 1 from the next cycle, and all other outputs stay 0.
- R3: After the start, `vcc_en` rises once 96 ticks have been counted and `io_en` rises once 256 ticks have been counted. Only cycles with `osc_tick`=1 after the start edge count.
- R4: If `host_rst` was 0 in the start cycle, `clk_en` rises together with `io_en`.
- R5: If `host_rst` was 1 in the start cycle, `clk_en` stays 0 after the data-enable point until `host_rst` is 0. It then stays 1 even if `host_rst` rises again. If `host_rst` never drops, the clock starts at the reset-enable point.
- R6: From 448 ticks onward, `card_rst` equals `host_rst` in the same cycle, and `clk_en` is 1 whatever `host_rst` does. Before that point, `card_rst` is 0.
- R7: When `sess_n` is sampled high in a session, `card_rst` is 0 from the next cycle. Counting ticks from that edge, `clk_en` falls at 32, `io_en` at 64, `vcc_en` at 96 and `pump_en` at 320.
- R8: `status_n` is 1 when `pres_hi`=1 or `pres_lo_n`=0, and is 0 otherwise, unless a fault is latched.
- R9: During ramp-up or in the live state, any of `ovc_flag`=1, `ovt_flag`=1, `supply_ok`=0 or a card removal starts a deactivation with the R7 timing on the next edge, and `status_n` is 0 from then on. An output that was still off when the fault arrived stays off.
- R10: A removal is the first cycle in which presence goes from true to false, with no filtering. The fault stays latched, so `status_n` stays 0 whatever presence does, until `sess_n` is sampled high.
- R11: While `supply_inhibit` is 1, no session starts whatever `sess_n` does.
- R12: After a session ends, no new one starts until the block is back in idle and `sess_n` has been seen high there. This also applies after reset.
- R13: Cycles with `osc_tick`=0 never move the schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse per slow-oscillator period |
| sess_n | input | 1 | Host session command, low requests power-up |
| host_rst | input | 1 | Host reset request for the card |
| pres_hi | input | 1 | Card-present switch, active high |
| pres_lo_n | input | 1 | Card-present switch, active low |
| ovc_flag | input | 1 | Card supply overcurrent |
| ovt_flag | input | 1 | Die overtemperature |
| supply_ok | input | 1 | Host supply above threshold |
| supply_inhibit | input | 1 | Supply-settling window, blocks a start |
| pump_en | output | 1 | Charge-pump enable |
| vcc_en | output | 1 | Card supply enable |
| io_en | output | 1 | Data-line buffer enable |
| clk_en | output | 1 | Card clock enable |
| card_rst | output | 1 | Reset to the card |
| status_n | output | 1 | Presence / fault flag, low means absent or fault |

## Verification
A fault and a ramp step can land on the same clock edge. The sharpest case is the tick that would move the block from ramp-up into the live state and enable the card reset. The bench raises a fault flag in exactly the cycle that carries tick 448, and also places faults at random ticks across the ramp. The expected result is that `card_rst` never rises. The clock, data lines and supply that were already on fall on the backward schedule. Any output still off at the fault stays off.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RAMP = 2'd1,
    SQ_LIVE = 2'd2,
    SQ_DOWN = 2'd3
  } sq_state_e;

  // schedule points, in half time units
  localparam int unsigned H_VCC_ON   = 3;
  localparam int unsigned H_IO_ON    = 8;
  localparam int unsigned H_RST_ON   = 14;
  localparam int unsigned H_DOWN_LEN = 10;
  localparam int unsigned H_DOWN_CLK = H_DOWN_LEN;
  localparam int unsigned H_DOWN_IO  = H_DOWN_LEN - 1;
  localparam int unsigned H_DOWN_VCC = H_DOWN_LEN - 2;
  localparam int unsigned STEP_W     = $clog2(H_RST_ON + 1);

  typedef struct packed {
    logic clk;
    logic io;
    logic vcc;
  } sq_live_t;

endpackage

// File: rtl/cseq_half_timer.sv
module cseq_half_timer #(
  parameter int unsigned TICKS_PER_T = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  input  logic tick,
  output logic half_done
);
  localparam int unsigned HALF  = TICKS_PER_T / 2;
  localparam int unsigned SUB_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [SUB_W-1:0] sub_q, sub_d;

  always_comb begin
    half_done = run & tick & (sub_q == SUB_W'(HALF - 1));
    if (clr || !run) begin
      sub_d = '0;
    end else if (tick) begin
      sub_d = half_done ? '0 : sub_q + 1'b1;
    end else begin
      sub_d = sub_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sub_q <= '0;
    else        sub_q <= sub_d;
  end

  p_sub_bound_r13: assert property (@(posedge clk) disable iff (!rst_n)
    sub_q <= SUB_W'(HALF - 1));

endmodule

// File: rtl/cseq_card_watch.sv
module cseq_card_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic pres_hi,
  input  logic pres_lo_n,
  input  logic ovc_flag,
  input  logic ovt_flag,
  input  logic supply_ok,
  input  logic sess_n,
  input  logic in_session,
  output logic present,
  output logic fault_evt,
  output logic fault_lat,
  output logic status_n
);
  logic pres_q;
  logic lat_d;
  logic removal;
  logic fault_raw;

  always_comb begin
    present   = pres_hi | ~pres_lo_n;
    removal   = pres_q & ~present;
    fault_raw = removal | ovc_flag | ovt_flag | ~supply_ok;
    fault_evt = in_session & fault_raw;
    lat_d     = sess_n ? 1'b0 : (fault_lat | fault_evt);
    status_n  = present & ~fault_lat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_q    <= 1'b0;
      fault_lat <= 1'b0;
    end else begin
      pres_q    <= present;
      fault_lat <= lat_d;
    end
  end

  p_flag_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_session && fault_raw && !sess_n) |=> !status_n);

  p_latch_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_lat && !sess_n) |=> fault_lat);

endmodule

// File: rtl/cseq_out_decode.sv
module cseq_out_decode
  import cseq_pkg::*;
(
  input  sq_state_e         st,
  input  logic [STEP_W-1:0] step,
  input  sq_live_t          live,
  input  logic              hold,
  input  logic              seen,
  input  logic              host_rst,
  output logic              pump_en,
  output logic              vcc_en,
  output logic              io_en,
  output logic              clk_en,
  output logic              card_rst
);
  always_comb begin
    pump_en  = 1'b0;
    vcc_en   = 1'b0;
    io_en    = 1'b0;
    clk_en   = 1'b0;
    card_rst = 1'b0;
    case (st)
      SQ_RAMP: begin
        pump_en = 1'b1;
        vcc_en  = step >= STEP_W'(H_VCC_ON);
        io_en   = step >= STEP_W'(H_IO_ON);
        clk_en  = (step >= STEP_W'(H_IO_ON)) & (seen | ~hold | ~host_rst);
      end
      SQ_LIVE: begin
        pump_en  = 1'b1;
        vcc_en   = 1'b1;
        io_en    = 1'b1;
        clk_en   = 1'b1;
        card_rst = host_rst;
      end
      SQ_DOWN: begin
        pump_en = 1'b1;
        vcc_en  = live.vcc & (step >= STEP_W'(H_DOWN_VCC));
        io_en   = live.io  & (step >= STEP_W'(H_DOWN_IO));
        clk_en  = live.clk & (step >= STEP_W'(H_DOWN_CLK));
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/card_seq_ctrl.sv
module card_seq_ctrl
  import cseq_pkg::*;
#(
  parameter int unsigned TICKS_PER_T = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic sess_n,
  input  logic host_rst,
  input  logic pres_hi,
  input  logic pres_lo_n,
  input  logic ovc_flag,
  input  logic ovt_flag,
  input  logic supply_ok,
  input  logic supply_inhibit,
  output logic pump_en,
  output logic vcc_en,
  output logic io_en,
  output logic clk_en,
  output logic card_rst,
  output logic status_n
);
  sq_state_e         st_q, st_d;
  logic [STEP_W-1:0] step_q, step_d;
  sq_live_t          live_q, live_d;
  logic              hold_q, hold_d;
  logic              seen_q, seen_d;
  logic              armed_q, armed_d;
  logic              half_done, load_down, run_tmr;
  logic              present, fault_evt, fault_lat, in_session, start_ok;

  assign in_session = (st_q != SQ_IDLE);
  assign run_tmr    = (st_q == SQ_RAMP) || (st_q == SQ_DOWN);
  assign start_ok   = ~sess_n & armed_q & ~supply_inhibit & supply_ok & present & ~fault_lat;

  cseq_half_timer #(.TICKS_PER_T(TICKS_PER_T)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_tmr),
    .clr       (load_down),
    .tick      (osc_tick),
    .half_done (half_done)
  );

  cseq_card_watch u_watch (
    .clk        (clk),
    .rst_n      (rst_n),
    .pres_hi    (pres_hi),
    .pres_lo_n  (pres_lo_n),
    .ovc_flag   (ovc_flag),
    .ovt_flag   (ovt_flag),
    .supply_ok  (supply_ok),
    .sess_n     (sess_n),
    .in_session (in_session),
    .present    (present),
    .fault_evt  (fault_evt),
    .fault_lat  (fault_lat),
    .status_n   (status_n)
  );

  cseq_out_decode u_decode (
    .st       (st_q),
    .step     (step_q),
    .live     (live_q),
    .hold     (hold_q),
    .seen     (seen_q),
    .host_rst (host_rst),
    .pump_en  (pump_en),
    .vcc_en   (vcc_en),
    .io_en    (io_en),
    .clk_en   (clk_en),
    .card_rst (card_rst)
  );

  always_comb begin
    st_d      = st_q;
    step_d    = step_q;
    live_d    = live_q;
    hold_d    = hold_q;
    seen_d    = seen_q;
    armed_d   = armed_q;
    load_down = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        armed_d = armed_q | sess_n;
        if (start_ok) begin
          st_d    = SQ_RAMP;
          step_d  = '0;
          hold_d  = host_rst;
          seen_d  = 1'b0;
          armed_d = 1'b0;
        end
      end
      SQ_RAMP: begin
        seen_d = seen_q | clk_en;
        if (sess_n || fault_evt) begin
          st_d       = SQ_DOWN;
          step_d     = STEP_W'(H_DOWN_LEN);
          live_d.clk = clk_en;
          live_d.io  = io_en;
          live_d.vcc = vcc_en;
          load_down  = 1'b1;
        end else if (half_done) begin
          if (step_q == STEP_W'(H_RST_ON - 1)) st_d = SQ_LIVE;
          step_d = step_q + 1'b1;
        end
      end
      SQ_LIVE: begin
        if (sess_n || fault_evt) begin
          st_d      = SQ_DOWN;
          step_d    = STEP_W'(H_DOWN_LEN);
          live_d    = '{clk: 1'b1, io: 1'b1, vcc: 1'b1};
          load_down = 1'b1;
        end
      end
      SQ_DOWN: begin
        if (half_done) begin
          step_d = step_q - 1'b1;
          if (step_q == STEP_W'(1)) st_d = SQ_IDLE;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      step_q  <= '0;
      live_q  <= '0;
      hold_q  <= 1'b0;
      seen_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      step_q  <= step_d;
      live_q  <= live_d;
      hold_q  <= hold_d;
      seen_q  <= seen_d;
      armed_q <= armed_d;
    end
  end

  p_vcc_pump_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_en |-> pump_en);

  p_io_vcc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    io_en |-> vcc_en);

  p_rst_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> (io_en && clk_en));

  p_start_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pump_en) |-> $past(!supply_inhibit && !sess_n && supply_ok));

  p_fault_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == SQ_RAMP || st_q == SQ_LIVE) && fault_evt) |=> (st_q == SQ_DOWN));

  p_down_monotone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_DOWN && $past(st_q) == SQ_DOWN) |->
      (!$rose(vcc_en) && !$rose(io_en) && !$rose(clk_en)));

  p_stall_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_RAMP && !osc_tick && !sess_n && !fault_evt) |=> $stable(step_q));

endmodule

// File: tb/card_seq_ctrl_test.sv
module card_seq_ctrl_test;
  localparam int VCC_K  = 96;
  localparam int IO_K   = 256;
  localparam int ON_K   = 448;
  localparam int D_CLK  = 32;
  localparam int D_IO   = 64;
  localparam int D_VCC  = 96;
  localparam int D_PUMP = 320;

  logic clk = 1'b0;
  logic rst_n, osc_tick, sess_n, host_rst, pres_hi, pres_lo_n;
  logic ovc_flag, ovt_flag, supply_ok, supply_inhibit;
  logic pump_en, vcc_en, io_en, clk_en, card_rst, status_n;

  int checks = 0;
  int errors = 0;
  int k = 0;
  bit started = 0;
  bit done = 0;
  logic [5:0] last_e;
  logic [2:0] lv;
  int cyc_count = 0;

  card_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .sess_n(sess_n),
    .host_rst(host_rst), .pres_hi(pres_hi), .pres_lo_n(pres_lo_n),
    .ovc_flag(ovc_flag), .ovt_flag(ovt_flag), .supply_ok(supply_ok),
    .supply_inhibit(supply_inhibit), .pump_en(pump_en), .vcc_en(vcc_en),
    .io_en(io_en), .clk_en(clk_en), .card_rst(card_rst), .status_n(status_n)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc_count <= cyc_count + 1;
    if (cyc_count == 190000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input bit t);
    osc_tick = t;
    @(posedge clk);
    #1;
  endtask

  // {pump, vcc, io, clk, card_rst, status_n}
  task automatic chk_vec(input string rq, input logic [5:0] e);
    logic [5:0] a;
    a = {pump_en, vcc_en, io_en, clk_en, card_rst, status_n};
    checks = checks + 1;
    if (a !== e) begin
      errors = errors + 1;
      $display("FAIL %s: outputs %b expected %b (k=%0d)", rq, a, e, k);
    end
  endtask

  function automatic logic [5:0] exp_ramp(int kk, bit hold, bit st, bit rq);
    bit v, i, on, c;
    v  = kk >= VCC_K;
    i  = kk >= IO_K;
    on = kk >= ON_K;
    c  = on || (i && (!hold || started || !rq));
    return {1'b1, v, i, c, on && rq, st};
  endfunction

  function automatic logic [5:0] exp_down(int m, logic [2:0] l, bit st);
    return {m < D_PUMP, l[0] && m < D_VCC, l[1] && m < D_IO, l[2] && m < D_CLK, 1'b0, st};
  endfunction

  task automatic arm();
    sess_n = 1'b1;
    cyc(1'($urandom % 2));
    cyc(0);
    chk_vec("R8 idle before start", 6'b000001);
  endtask

  task automatic start(input bit hold);
    host_rst = hold;
    sess_n = 1'b0;
    cyc(1'($urandom % 2));
    k = 0;
    started = 0;
    last_e = 6'b100001;
    chk_vec("R2 start", 6'b100001);
  endtask

  task automatic apply_fault(input int kind);
    case (kind)
      0: ovc_flag = 1'b1;
      1: ovt_flag = 1'b1;
      2: supply_ok = 1'b0;
      default: begin pres_hi = 1'b0; pres_lo_n = 1'b1; end
    endcase
  endtask

  // returns 1 when a fault was injected
  task automatic act_run(input int kmax, input bit hold, input int drop_k, input int rise_k,
                         input int fault_k, input int kind, output bit faulted);
    logic [5:0] e;
    bit t;
    string tag;
    faulted = 0;
    while (k < kmax) begin
      if (k == fault_k) begin
        lv = {last_e[2], last_e[3], last_e[4]};
        apply_fault(kind);
        cyc(1);
        ovc_flag = 1'b0;
        ovt_flag = 1'b0;
        supply_ok = 1'b1;
        faulted = 1;
        return;
      end
      t = ($urandom % 4) != 0;
      if (!hold || k >= ON_K) host_rst = 1'($urandom % 2);
      else if (drop_k >= 0 && k >= drop_k && (rise_k < 0 || k < rise_k)) host_rst = 1'b0;
      else host_rst = 1'b1;
      cyc(t);
      if (t) k = k + 1;
      e = exp_ramp(k, hold, 1'b1, host_rst);
      if (!t) tag = "R13 idle cycle";
      else if (k < IO_K) tag = "R3 ramp";
      else if (k < ON_K) tag = hold ? "R5 hold clock" : "R4 clock start";
      else tag = "R6 reset follow";
      chk_vec(tag, e);
      if (e[2]) started = 1;
      last_e = e;
    end
  endtask

  task automatic deact_run(input logic [2:0] l, input bit st, input bit bounce, input string tag);
    int m;
    bit t;
    m = 0;
    chk_vec(tag, exp_down(0, l, st));
    while (m < D_PUMP) begin
      t = ($urandom % 4) != 0;
      if (bounce) pres_hi = 1'($urandom % 2);
      cyc(t);
      if (t) m = m + 1;
      chk_vec(t ? tag : "R13 idle cycle down", exp_down(m, l, st));
    end
  endtask

  task automatic post_emergency();
    pres_hi = 1'b1;
    pres_lo_n = 1'b1;
    for (int j = 0; j < 12; j++) begin
      cyc(1'($urandom % 2));
      chk_vec("R12 no restart while low", 6'b000000);
    end
    sess_n = 1'b1;
    cyc(0);
    chk_vec("R10 latch cleared by high", 6'b000001);
  endtask

  task automatic normal_session(input bit hold, input int drop_k, input int rise_k);
    bit f;
    arm();
    start(hold);
    act_run(ON_K + 12, hold, drop_k, rise_k, -1, 0, f);
    sess_n = 1'b1;
    cyc(1'($urandom % 2));
    deact_run(3'b111, 1'b1, 1'b0, "R7 normal down");
  endtask

  task automatic fault_session(input bit hold, input int fault_k, input int kind);
    bit f;
    arm();
    start(hold);
    act_run(ON_K + 12, hold, -1, -1, fault_k, kind, f);
    if (f) begin
      deact_run(lv, 1'b0, kind == 3, "R9 emergency down");
      post_emergency();
    end else begin
      sess_n = 1'b1;
      cyc(0);
      deact_run(3'b111, 1'b1, 1'b0, "R7 normal down");
    end
  endtask

  initial begin
    bit f;
    void'($urandom(32'd2024));
    rst_n = 1'b0; osc_tick = 1'b0; sess_n = 1'b0; host_rst = 1'b0;
    pres_hi = 1'b0; pres_lo_n = 1'b0; ovc_flag = 1'b0; ovt_flag = 1'b0;
    supply_ok = 1'b1; supply_inhibit = 1'b0;
    repeat (3) cyc(1);
    chk_vec("R1 in reset", 6'b000001);
    rst_n = 1'b1;
    for (int j = 0; j < 4; j++) begin
      cyc(1);
      chk_vec("R12 no start before high seen", 6'b000001);
    end
    pres_lo_n = 1'b1;
    cyc(0);
    chk_vec("R8 absent", 6'b000000);
    pres_hi = 1'b1;
    cyc(0);
    chk_vec("R8 present high pin", 6'b000001);
    // no card: session refused
    sess_n = 1'b1; cyc(0);
    pres_hi = 1'b0;
    sess_n = 1'b0;
    for (int j = 0; j < 5; j++) begin
      cyc(1);
      chk_vec("R2 refused without card", 6'b000000);
    end
    pres_hi = 1'b1;

    // plain session, clock starts with data lines
    normal_session(1'b0, -1, -1);
    // hold mode: clock starts on drop, stays on after rise
    normal_session(1'b1, 300, 340);
    // hold never dropped, overtemperature in live state
    fault_session(1'b1, ON_K + 7, 1);
    // overcurrent during ramp, supply on but data lines still off
    fault_session(1'b0, 150, 0);
    // card removal in live state, presence bounces afterwards
    fault_session(1'b0, ON_K + 4, 3);
    // fault on the very tick that would reach the live state
    fault_session(1'b0, ON_K - 1, 1);

    // inhibit window blocks start
    arm();
    supply_inhibit = 1'b1;
    sess_n = 1'b0;
    for (int j = 0; j < 20; j++) begin
      cyc(1'($urandom % 2));
      chk_vec("R11 inhibit blocks start", 6'b000001);
    end
    supply_inhibit = 1'b0;
    host_rst = 1'b0;
    cyc(1);
    k = 0; started = 0; last_e = 6'b100001;
    chk_vec("R11 start after inhibit", 6'b100001);
    act_run(ON_K, 1'b0, -1, -1, 50, 2, f);
    deact_run(lv, 1'b0, 1'b0, "R9 supply drop down");
    post_emergency();

    // random sessions
    for (int s = 0; s < 5; s++) begin
      fault_session(1'($urandom % 2), int'($urandom % 480), int'($urandom % 4));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule